// File: doc/BRIEF.md
# Byte-Stream Packet Interface

This peripheral connects host software to a byte-wide packet stream through a small word-addressed register window. Software probes the device by reading a fixed 64-bit identifier. It reads received frames out one byte per access from a data port, and a count register falls by one on each of those reads. To send, software writes a frame length and then writes that many bytes into a transmit data port. Once the last byte is in, the block sends the frame on its outgoing stream.

Both streams use a valid/ready handshake and carry start-of-frame and end-of-frame markers on each byte. A flag register records three events: transmit done, receive available and a software-raised test interrupt. Software clears the first two by writing ones to them. The interrupt output is high while any of the three is pending. While the receive flag is set, or while unread receive bytes remain, the incoming stream is held off and no new frame can land.

The host port is a single-cycle bus. A read returns data in the same cycle its strobe is high. Side effects of the access take place at the next rising clock edge. Register offsets: 0x00 and 0x04 hold the identifier, 0x08 busy, 0x0C receive count, 0x10 transmit count, 0x14 interrupt flags, 0x18 interrupt info (reads 0), 0x1C receive data and 0x20 transmit data.

Top module: `pktport_nic`

## Requirements
- R1: Reads at 0x00 and 0x04 return the identifier low and high words, 0x50544B50 and 0x3154524F, which are the ASCII text "PKTPORT1" in little-endian byte order.
- R2: Bit 0 of the busy register (0x08) reads 1 while an incoming frame is partly received or an outgoing frame is being sent, and reads 0 otherwise.
- R3: When the end-of-frame byte of an incoming frame is accepted, the receive count (0x0C) takes the frame length and bit 1 of the flag register (0x14) becomes 1.
- R4: Each read of 0x1C with a nonzero count returns the next frame byte, in arrival order, in bits 7:0 with bits 31:8 zero, and lowers the count by one.
- R5: A read of 0x1C while the receive count is zero returns 0 and leaves the count at zero.
- R6: rx_ready is low, and no frame is taken in, while flag bit 1 is set or the receive count is nonzero. When idle, a byte without the start marker is accepted and discarded.
- R7: After a length write to 0x10, each write to 0x20 stores bits 7:0 and lowers the count read at 0x10. The last byte sends the frame on tx_*, with start marker on the first byte, end marker on the last, bytes in order, and outputs held steady while tx_ready is low.
- R8: A write to 0x20 while the transmit count is zero is ignored, and a length write while a frame is being sent is ignored.
- R9: Flag bit 0 becomes 1 when the end-of-frame byte of an outgoing frame is handed off. Writing 1 to bit 0 or bit 1 of 0x14 clears that bit, and a set event in the same cycle wins.
- R10: Writing a nonzero word with bit 31 set to 0x14 raises the test flag. A read of 0x14 returns bit 31 set and then clears it. Writing 0 to 0x14 also clears it.
- R11: irq is high exactly when flag bit 0, flag bit 1 or the test flag is set.
- R12: An incoming frame longer than BUF_DEPTH keeps its first BUF_DEPTH bytes and reports a count of BUF_DEPTH. A length write above BUF_DEPTH is clamped to BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_sof | input | 1 | Incoming byte starts a frame |
| rx_eof | input | 1 | Incoming byte ends a frame |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_sof | output | 1 | Outgoing byte starts a frame |
| tx_eof | output | 1 | Outgoing byte ends a frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check several rules on every cycle:
- the receive count falls by exactly one per data-port read and stays at zero on an empty read;
- no frame starts while the receive flag is up or bytes remain;
- outgoing bytes hold steady under back-pressure;
- the write-one-to-clear and read-clear rules of the flag register;
- the count never exceeds the buffer depth.

Byte order, the identifier value, the truncation of oversized frames and the discarding of stray bytes depend on the data carried through a whole frame. Only the bench's directed scenarios can show those.

// File: rtl/pktport_pkg.sv
package pktport_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_ID_LO  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_ID_HI  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_BUSY   = 6'h08;
    localparam logic [REG_AW-1:0] OFS_RXCNT  = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_TXCNT  = 6'h10;
    localparam logic [REG_AW-1:0] OFS_FLAGS  = 6'h14;
    localparam logic [REG_AW-1:0] OFS_INFO   = 6'h18;
    localparam logic [REG_AW-1:0] OFS_RXDAT  = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_TXDAT  = 6'h20;

    localparam int BIT_TXDONE = 0;
    localparam int BIT_RXAVL  = 1;
    localparam int BIT_TEST   = 31;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
    } beat_t;

    typedef struct packed {
        logic test;
        logic rx;
        logic tx;
    } flags_t;

    function automatic logic [31:0] flags_word(flags_t f);
        logic [31:0] w;
        w = '0;
        w[BIT_TEST]   = f.test;
        w[BIT_RXAVL]  = f.rx;
        w[BIT_TXDONE] = f.tx;
        return w;
    endfunction

endpackage

// File: rtl/pktport_rx.sv
module pktport_rx
    import pktport_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                           clk,
    input  logic                           rst,
    input  beat_t                          in_beat,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic                           hold,
    input  logic                           pop,
    output logic [7:0]                     rd_byte,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           frame_done,
    output logic                           filling
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] wptr, rptr, cnt;
    logic          fill_q;
    logic          idle_ok, take, room;

    assign idle_ok    = !fill_q && !hold && (cnt == '0);
    assign in_ready   = fill_q || idle_ok;
    assign take       = in_valid && in_ready && (fill_q || in_beat.sof);
    assign room       = wptr < CW'(DEPTH);
    assign frame_done = take && in_beat.eof;
    assign count      = cnt;
    assign filling    = fill_q;
    assign rd_byte    = (cnt != '0) ? mem[rptr[AW-1:0]] : 8'h00;

    always_ff @(posedge clk) begin
        if (take && room) begin
            mem[wptr[AW-1:0]] <= in_beat.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= 1'b0;
            wptr   <= '0;
            rptr   <= '0;
            cnt    <= '0;
        end else begin
            if (take) begin
                if (in_beat.eof) begin
                    fill_q <= 1'b0;
                    wptr   <= '0;
                    rptr   <= '0;
                    cnt    <= room ? wptr + 1'b1 : wptr;
                end else begin
                    fill_q <= 1'b1;
                    if (room) wptr <= wptr + 1'b1;
                end
            end
            if (pop && cnt != '0) begin
                cnt  <= cnt - 1'b1;
                rptr <= rptr + 1'b1;
            end
        end
    end

    p_pop_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt == '0 && !frame_done) |=> (cnt == '0));

    p_no_start_r6: assert property (@(posedge clk) disable iff (rst)
        ((hold || cnt != '0) && !fill_q) |=> !fill_q);

    p_len_cap_r12: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/pktport_tx.sv
module pktport_tx
    import pktport_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           len_wr,
    input  logic [31:0]                    len_val,
    input  logic                           dat_wr,
    input  logic [7:0]                     dat_byte,
    output logic [$clog2(DEPTH+1)-1:0]     remaining,
    output logic                           sending,
    output beat_t                          out_beat,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic                           done
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] len_q, rem, wptr, sptr;
    logic [CW-1:0] len_clamped;
    logic          send_q, last, store;

    assign len_clamped = (len_val > 32'(DEPTH)) ? CW'(DEPTH) : len_val[CW-1:0];
    assign store       = dat_wr && (rem != '0);
    assign last        = (sptr == len_q - 1'b1);

    assign remaining      = rem;
    assign sending        = send_q;
    assign out_valid      = send_q;
    assign out_beat.data  = mem[sptr[AW-1:0]];
    assign out_beat.sof   = send_q && (sptr == '0);
    assign out_beat.eof   = send_q && last;
    assign done           = send_q && out_ready && last;

    always_ff @(posedge clk) begin
        if (store) begin
            mem[wptr[AW-1:0]] <= dat_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            rem    <= '0;
            wptr   <= '0;
            sptr   <= '0;
            send_q <= 1'b0;
        end else begin
            if (len_wr && !send_q) begin
                len_q <= len_clamped;
                rem   <= len_clamped;
                wptr  <= '0;
            end else if (store) begin
                wptr <= wptr + 1'b1;
                rem  <= rem - 1'b1;
                if (rem == CW'(1)) begin
                    send_q <= 1'b1;
                    sptr   <= '0;
                end
            end
            if (send_q && out_ready) begin
                sptr <= sptr + 1'b1;
                if (last) send_q <= 1'b0;
            end
        end
    end

    p_hold_out_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)));

    p_done_ends_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !send_q);

    p_len_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (send_q && len_wr) |=> (rem == '0));

    p_idle_write_r8: assert property (@(posedge clk) disable iff (rst)
        (rem == '0 && !len_wr) |=> (rem == '0));

endmodule

// File: rtl/pktport_irq.sv
module pktport_irq
    import pktport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_set,
    input  logic        rx_set,
    input  logic        wr,
    input  logic        rd,
    input  logic [31:0] wdata,
    output flags_t      flags,
    output logic        irq
);
    flags_t f_q;

    assign flags = f_q;
    assign irq   = f_q.tx || f_q.rx || f_q.test;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            if (wr && wdata[BIT_TXDONE]) f_q.tx <= 1'b0;
            if (tx_set)                  f_q.tx <= 1'b1;
            if (wr && wdata[BIT_RXAVL])  f_q.rx <= 1'b0;
            if (rx_set)                  f_q.rx <= 1'b1;
            if (wr) begin
                if (wdata == 32'h0)        f_q.test <= 1'b0;
                else if (wdata[BIT_TEST])  f_q.test <= 1'b1;
            end else if (rd) begin
                f_q.test <= 1'b0;
            end
        end
    end

    p_test_rdclr_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr) |=> !f_q.test);

    p_test_set_r10: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[BIT_TEST]) |=> f_q.test);

    p_w1c_tx_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[BIT_TXDONE] && !tx_set) |=> !f_q.tx);

    p_w1c_rx_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[BIT_RXAVL] && !rx_set) |=> !f_q.rx);

endmodule

// File: rtl/pktport_nic.sv
module pktport_nic
    import pktport_pkg::*;
#(
    parameter int          BUF_DEPTH = 256,
    parameter logic [63:0] DEV_ID    = 64'h3154524F_50544B50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int CW = $clog2(BUF_DEPTH + 1);

    beat_t         rx_beat, tx_beat;
    flags_t        flags;
    logic [CW-1:0] rx_cnt, tx_rem;
    logic [7:0]    rx_byte;
    logic          rx_done, rx_fill, tx_send, tx_done;
    logic          len_wr, dat_wr, flg_wr, flg_rd, pop;

    assign rx_beat = '{data: rx_data, sof: rx_sof, eof: rx_eof};

    assign len_wr = bus_wr && (bus_addr == OFS_TXCNT);
    assign dat_wr = bus_wr && (bus_addr == OFS_TXDAT);
    assign flg_wr = bus_wr && (bus_addr == OFS_FLAGS);
    assign flg_rd = bus_rd && (bus_addr == OFS_FLAGS);
    assign pop    = bus_rd && (bus_addr == OFS_RXDAT);

    pktport_rx #(.DEPTH(BUF_DEPTH)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .in_beat    (rx_beat),
        .in_valid   (rx_valid),
        .in_ready   (rx_ready),
        .hold       (flags.rx),
        .pop        (pop),
        .rd_byte    (rx_byte),
        .count      (rx_cnt),
        .frame_done (rx_done),
        .filling    (rx_fill)
    );

    pktport_tx #(.DEPTH(BUF_DEPTH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .len_wr    (len_wr),
        .len_val   (bus_wdata),
        .dat_wr    (dat_wr),
        .dat_byte  (bus_wdata[7:0]),
        .remaining (tx_rem),
        .sending   (tx_send),
        .out_beat  (tx_beat),
        .out_valid (tx_valid),
        .out_ready (tx_ready),
        .done      (tx_done)
    );

    pktport_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .tx_set (tx_done),
        .rx_set (rx_done),
        .wr     (flg_wr),
        .rd     (flg_rd),
        .wdata  (bus_wdata),
        .flags  (flags),
        .irq    (irq)
    );

    assign tx_data = tx_beat.data;
    assign tx_sof  = tx_beat.sof;
    assign tx_eof  = tx_beat.eof;

    always_comb begin
        bus_rdata = 32'h0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_ID_LO: bus_rdata = DEV_ID[31:0];
                OFS_ID_HI: bus_rdata = DEV_ID[63:32];
                OFS_BUSY:  bus_rdata = {31'h0, rx_fill || tx_send};
                OFS_RXCNT: bus_rdata = 32'(rx_cnt);
                OFS_TXCNT: bus_rdata = 32'(tx_rem);
                OFS_FLAGS: bus_rdata = flags_word(flags);
                OFS_RXDAT: bus_rdata = {24'h0, rx_byte};
                default:   bus_rdata = 32'h0;
            endcase
        end
    end

    p_irq_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (flags.tx || flags.rx || flags.test));

endmodule

// File: tb/test_pktport_nic.sv
`timescale 1ns/1ps
module test_pktport_nic;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic        rx_valid, rx_sof, rx_eof, rx_ready;
    logic [7:0]  rx_data;
    logic        tx_valid, tx_sof, tx_eof, tx_ready;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int bp_mode = 0;
    logic [7:0] cap_d [32];
    logic       cap_s [32];
    logic       cap_e [32];
    int cap_n = 0;

    always #2 clk = ~clk;

    pktport_nic #(.BUF_DEPTH(DEPTH)) i_pktport_nic (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_ready(tx_ready), .irq(irq)
    );

    always @(negedge clk) begin
        case (bp_mode)
            0:       tx_ready <= 1'b0;
            1:       tx_ready <= 1'b1;
            default: tx_ready <= ~tx_ready;
        endcase
    end

    always @(posedge clk) begin
        if (tx_valid && tx_ready && cap_n < 32) begin
            cap_d[cap_n] = tx_data;
            cap_s[cap_n] = tx_sof;
            cap_e[cap_n] = tx_eof;
            cap_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rx_beat(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e;
        #1;
        while (!rx_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R2 busy after reset", {31'h0, 1'b0}, 32'h0);
        bus_read(6'h08, v); check("R2 busy idle", v, 32'h0);
        bus_read(6'h0C, v); check("R3 rx count reset", v, 32'h0);
        bus_read(6'h10, v); check("R7 tx count reset", v, 32'h0);
        check("R6 rx_ready reset", {31'h0, rx_ready}, 32'h1);
        check("R11 irq reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        bus_read(6'h00, v); check("R1 id low", v, 32'h50544B50);
        bus_read(6'h04, v); check("R1 id high", v, 32'h3154524F);
    endtask

    task automatic t_rx_basic();
        logic [31:0] v;
        rx_beat(8'hA1, 1'b1, 1'b0);
        bus_read(6'h08, v); check("R2 busy while receiving", v, 32'h1);
        rx_beat(8'hB2, 1'b0, 1'b0);
        rx_beat(8'hC3, 1'b0, 1'b1);
        bus_read(6'h08, v); check("R2 busy after frame", v, 32'h0);
        bus_read(6'h0C, v); check("R3 rx count", v, 32'd3);
        bus_read(6'h14, v); check("R3 rx flag", v, 32'h2);
        check("R11 irq on rx flag", {31'h0, irq}, 32'h1);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hEE; rx_sof = 1'b1; rx_eof = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1 check("R6 ready low while flag set", {31'h0, rx_ready}, 32'h0);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        bus_read(6'h1C, v); check("R4 byte 0", v, 32'hA1);
        bus_read(6'h0C, v); check("R4 count after 1", v, 32'd2);
        bus_read(6'h1C, v); check("R4 byte 1", v, 32'hB2);
        bus_read(6'h1C, v); check("R4 byte 2", v, 32'hC3);
        bus_read(6'h0C, v); check("R4 count drained", v, 32'd0);
        bus_read(6'h1C, v); check("R5 empty read value", v, 32'h0);
        bus_read(6'h0C, v); check("R5 count stays zero", v, 32'd0);
        bus_write(6'h14, 32'h2);
        bus_read(6'h14, v); check("R9 rx flag cleared", v, 32'h0);
        check("R11 irq low after clear", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_rx_long();
        logic [31:0] v;
        rx_beat(8'h99, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) rx_beat(8'h40 + 8'(i), i == 0, i == 19);
        bus_read(6'h0C, v); check("R12 truncated count", v, DEPTH);
        bus_write(6'h14, 32'h2);
        @(negedge clk); #1;
        check("R6 ready low while bytes remain", {31'h0, rx_ready}, 32'h0);
        bus_read(6'h1C, v); check("R6 stray byte dropped", v, 32'h40);
        for (int i = 1; i < DEPTH; i++) begin
            bus_read(6'h1C, v);
            if (i == DEPTH - 1) check("R12 last kept byte", v, 32'h40 + i);
        end
        @(negedge clk); #1;
        check("R6 ready back after drain", {31'h0, rx_ready}, 32'h1);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        int wait_n;
        bp_mode = 0;
        bus_write(6'h10, 32'd5);
        bus_read(6'h10, v); check("R7 tx count loaded", v, 32'd5);
        bus_write(6'h20, 32'hFFFF_FF10);
        bus_write(6'h20, 32'h11);
        bus_read(6'h10, v); check("R7 tx count after 2", v, 32'd3);
        bus_write(6'h20, 32'h12);
        bus_write(6'h20, 32'h13);
        bus_write(6'h20, 32'h14);
        bus_read(6'h10, v); check("R7 tx count taken in", v, 32'd0);
        bus_read(6'h08, v); check("R2 busy while sending", v, 32'h1);
        check("R7 first beat held", {22'h0, tx_valid, tx_sof, tx_data}, {22'h0, 1'b1, 1'b1, 8'h10});
        bus_write(6'h10, 32'd4);
        bus_read(6'h10, v); check("R8 length write ignored while sending", v, 32'd0);
        bp_mode = 2;
        wait_n = 0;
        while (cap_n < 5 && wait_n < 100) begin
            @(negedge clk); wait_n++;
        end
        bp_mode = 1;
        check("R7 beats sent", cap_n, 32'd5);
        for (int i = 0; i < 5; i++) begin
            check("R7 tx byte", cap_d[i], 8'h10 + 8'(i));
            check("R7 tx markers", {cap_s[i], cap_e[i]}, {i == 0, i == 4});
        end
        bus_read(6'h14, v); check("R9 tx done flag", v, 32'h1);
        check("R11 irq on tx flag", {31'h0, irq}, 32'h1);
        bus_write(6'h14, 32'h1);
        bus_read(6'h14, v); check("R9 tx flag cleared", v, 32'h0);
        bus_write(6'h20, 32'h55);
        repeat (3) @(negedge clk);
        check("R8 idle data write sends nothing", {31'h0, tx_valid}, 32'h0);
        bus_read(6'h10, v); check("R8 idle data write count", v, 32'd0);
        bus_write(6'h10, 32'd1000);
        bus_read(6'h10, v); check("R12 length clamped", v, DEPTH);
    endtask

    task automatic t_test_irq();
        logic [31:0] v;
        bus_write(6'h14, 32'h8000_0000);
        @(negedge clk); check("R11 irq on test", {31'h0, irq}, 32'h1);
        bus_read(6'h14, v); check("R10 test bit read", v, 32'h8000_0000);
        bus_read(6'h14, v); check("R10 test bit cleared by read", v, 32'h0);
        check("R11 irq low after test", {31'h0, irq}, 32'h0);
        bus_write(6'h14, 32'h8000_0000);
        bus_write(6'h14, 32'h0);
        @(negedge clk); check("R10 zero write clears test", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0; rx_eof = 1'b0; tx_ready = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_id();
        t_rx_basic();
        t_rx_long();
        t_test_irq();
        t_tx();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule